// File: doc/BRIEF.md
# External Parallel Memory Cycle Sequencer

This block sits between an internal requester and an external parallel ROM or Flash device. It accepts one request at a time: a 23-bit word address, a write flag and 16 bits of write data. It then runs a complete bus cycle, with each strobe edge placed on a whole internal clock period. The device is reached through active-low select, read-strobe and write-strobe lines and a 16-bit data bus. The bus is presented as separate in, out and drive-enable signals, so the pad ring can build the tri-state buffer.

In a read cycle the select line and the address go out first. The read strobe follows after a setup interval and stays low for a fixed pulse. The data bus is sampled on the edge that ends the pulse. In a write cycle the block drives the bus from the first clock of the cycle. The write strobe follows after its own setup interval, and the bus is released one clock after the write strobe rises. Every cycle ends with a turnaround period. This gives the device time to release the bus before the next cycle can start. A one-clock `done` pulse then reports completion.

Default timing: a read holds select low for 5 clocks (2 setup + 3 pulse). A write holds select low for 6 clocks (2 setup + 4 pulse). One turnaround clock follows each cycle.

Top module: `xmem_cycle_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe`, `busy` and `done` are 0. `rd_data` and `mem_addr` are 0.
- R2: A request (`req_valid` = 1 at a rising edge) is taken only while the block is idle. A request made while `busy` is 1 starts no cycle and leaves `mem_addr` unchanged. The idle state is reached on the edge that raises `done`, so a request can be taken on the next edge.
- R3: A read is taken at edge k. `mem_cs_n` is 0 from edge k to edge k+5. `mem_oe_n` is 0 from edge k+2 to edge k+5, which is 3 clocks. `mem_we_n` stays 1.
- R4: The value on `mem_dq_in` at edge k+5 of a read (the edge where `mem_oe_n` rises) appears on `rd_data`. It is valid from that edge onward and is still present while `done` is 1.
- R5: A write is taken at edge k. `mem_cs_n` is 0 from edge k to edge k+6. `mem_we_n` is 0 from edge k+2 to edge k+6, which is 4 clocks. `mem_oe_n` stays 1.
- R6: For a write taken at edge k, `mem_dq_oe` is 1 from edge k to edge k+7, which is one clock after `mem_we_n` rises. During that time `mem_dq_out` equals the request's write data. `mem_dq_oe` is 0 at all other times, including all of every read.
- R7: `done` is 1 for exactly one clock. It rises one turnaround clock after the strobes rise: edge k+6 for a read, edge k+7 for a write. `busy` is 1 from edge k until the edge where `done` rises.
- R8: `mem_oe_n` and `mem_we_n` are never both 0. Neither is 0 while `mem_cs_n` is 1.
- R9: `mem_addr` takes the request's address at edge k. It holds that value while `mem_cs_n` is 0 and until the next request is taken.
- R10: `rd_data` changes only at the end of a read pulse. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; all strobes are placed in its periods |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 23 | Word address of the request |
| req_wdata | input | 16 | Write data of the request |
| busy | output | 1 | High from request acceptance until completion |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| mem_addr | output | 23 | Device address |
| mem_cs_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Device read strobe, active low |
| mem_we_n | output | 1 | Device write strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the device |
| mem_dq_oe | output | 1 | High when the block drives the data bus |
| mem_dq_in | input | 16 | Data returned by the device |

## Verification
The embedded assertions check these rules on every cycle:
- The two strobes are never low together, and neither is low outside select (R8).
- The address is stable while select is low (R9).
- `done` lasts one clock and never coincides with `busy` (R7).
- No cycle starts while busy (R2).
- The bus is never driven while the read strobe is low (R6).
- `rd_data` moves only at a read-pulse end (R10).

Only the bench's scenarios can show the exact edge counts of setup, pulse and turnaround, and that a request is taken on the first edge after `done`. The bench drives valid data only in the last pulse clock of a read, so only the bench can show that data is captured on that edge and not on a neighbour. Its cases also include rejected requests made while busy, and requests held high so that cycles run back to back.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_RECOV = 2'd3
  } xmem_state_e;

  function automatic int xmem_max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/xmem_cycle_fsm.sv
module xmem_cycle_fsm
  import xmem_pkg::*;
#(
  parameter int RD_SETUP  = 2,
  parameter int RD_PULSE  = 3,
  parameter int WR_SETUP  = 2,
  parameter int WR_PULSE  = 4,
  parameter int TURN_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic wr_q,
  output logic strobe_end,
  output logic in_recov,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic busy,
  output logic done
);

  localparam int CNT_MAX = xmem_max3(xmem_max3(RD_SETUP, RD_PULSE, WR_SETUP),
                                     WR_PULSE, TURN_CLKS);
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] RS_LD = CNT_W'(RD_SETUP - 1);
  localparam logic [CNT_W-1:0] RP_LD = CNT_W'(RD_PULSE - 1);
  localparam logic [CNT_W-1:0] WS_LD = CNT_W'(WR_SETUP - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TR_LD = CNT_W'(TURN_CLKS - 1);

  xmem_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cs_n_q, oe_n_q, we_n_q, busy_q, done_q, wr_r;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign strobe_end = (state_q == ST_PULSE) && cnt_zero;
  assign in_recov   = (state_q == ST_RECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_r    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_SETUP;
            cnt_q   <= req_write ? WS_LD : RS_LD;
            wr_r    <= req_write;
            cs_n_q  <= 1'b0;
            busy_q  <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_PULSE;
            cnt_q   <= wr_r ? WP_LD : RP_LD;
            if (wr_r) we_n_q <= 1'b0;
            else      oe_n_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_zero) begin
            state_q <= ST_RECOV;
            cnt_q   <= TR_LD;
            cs_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n = cs_n_q;
  assign oe_n = oe_n_q;
  assign we_n = we_n_q;
  assign busy = busy_q;
  assign done = done_q;
  assign wr_q = wr_r;

  // R8: strobes mutually exclusive and confined to select
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n_q && !we_n_q));
  a_r8_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_q || !we_n_q) |-> !cs_n_q);
  // R7: done is a single-clock pulse, never overlapping busy
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R2: no acceptance while busy
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !accept);
  // R3: select only falls after an accepted request
  a_r3_select_from_accept: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> $past(accept));

endmodule

// File: rtl/xmem_dq_path.sv
module xmem_dq_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              strobe_end,
  input  logic              wr_q,
  input  logic              in_recov,
  input  logic [DATA_W-1:0] dq_in,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);

  logic              dq_oe_q;
  logic [DATA_W-1:0] dq_out_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_capture;

  assign rd_capture = strobe_end && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe_q  <= 1'b0;
      dq_out_q <= '0;
      rd_q     <= '0;
    end else begin
      if (accept && req_write) begin
        dq_oe_q  <= 1'b1;
        dq_out_q <= req_wdata;
      end else if (in_recov) begin
        dq_oe_q  <= 1'b0;
      end
      if (rd_capture) rd_q <= dq_in;
    end
  end

  assign dq_oe   = dq_oe_q;
  assign dq_out  = dq_out_q;
  assign rd_data = rd_q;

  // R10: read data moves only at the end of a read pulse
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_capture) |-> $stable(rd_q));
  // R6: bus released only from the turnaround state
  a_r6_release_in_turn: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe_q) |-> $past(in_recov));

endmodule

// File: rtl/xmem_cycle_seq.sv
module xmem_cycle_seq #(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int RD_SETUP  = 2,
  parameter int RD_PULSE  = 3,
  parameter int WR_SETUP  = 2,
  parameter int WR_PULSE  = 4,
  parameter int TURN_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic accept, wr_q, strobe_end, in_recov;
  logic [ADDR_W-1:0] addr_q;

  xmem_cycle_fsm #(
    .RD_SETUP (RD_SETUP),
    .RD_PULSE (RD_PULSE),
    .WR_SETUP (WR_SETUP),
    .WR_PULSE (WR_PULSE),
    .TURN_CLKS(TURN_CLKS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .wr_q      (wr_q),
    .strobe_end(strobe_end),
    .in_recov  (in_recov),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .busy      (busy),
    .done      (done)
  );

  xmem_dq_path #(
    .DATA_W(DATA_W)
  ) u_dq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .strobe_end(strobe_end),
    .wr_q      (wr_q),
    .in_recov  (in_recov),
    .dq_in     (mem_dq_in),
    .dq_oe     (mem_dq_oe),
    .dq_out    (mem_dq_out),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign mem_addr = addr_q;

  // R9: address steady while select is low
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R6: never drive the bus while the device is asked to drive it
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

endmodule

// File: tb/xmem_cycle_seq_tb.sv
module xmem_cycle_seq_tb_top;

  localparam int RS = 2, RP = 3, WS = 2, WP = 4, TR = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic [22:0] mem_addr;

  int checks = 0, fails = 0, cyc = 0;

  // behavioural reference state
  int          mt = 0, m_last = 0;
  bit          m_wr = 0;
  logic [22:0] m_addr = '0;
  logic [15:0] m_wdata = '0, m_rdata = '0;

  always #2 clk = ~clk;

  xmem_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [15:0] dev_word(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h0} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // reference model advances on each edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mt = 0; m_rdata = '0; m_addr = '0;
    end else begin
      if (mt != 0 && !m_wr && mt == RS + RP) m_rdata = mem_dq_in;
      if (mt == 0 || mt == m_last) begin
        if (req_valid) begin
          mt = 1; m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
          m_last = (req_write ? WS + WP : RS + RP) + TR + 1;
        end else mt = 0;
      end else mt++;
    end
  end

  // compare away from the edge, then present device data
  always @(negedge clk) begin
    int s, p;
    bit strobe, e_cs_n, e_oe_n, e_we_n, e_oe, e_busy, e_done;
    s = m_wr ? WS : RS;
    p = m_wr ? WP : RP;
    strobe = (mt >= s + 1) && (mt <= s + p);
    e_cs_n = !(mt >= 1 && mt <= s + p);
    e_oe_n = !(!m_wr && strobe);
    e_we_n = !(m_wr && strobe);
    e_oe   = m_wr && mt >= 1 && mt <= s + p + 1;
    e_busy = mt >= 1 && mt < m_last;
    e_done = mt != 0 && mt == m_last;
    if (!rst) begin
      chk(mem_cs_n === e_cs_n, m_wr ? "R5" : "R3", "cs_n", 32'(mem_cs_n), 32'(e_cs_n));
      chk(mem_oe_n === e_oe_n, m_wr ? "R5" : "R3", "oe_n", 32'(mem_oe_n), 32'(e_oe_n));
      chk(mem_we_n === e_we_n, m_wr ? "R5" : "R3", "we_n", 32'(mem_we_n), 32'(e_we_n));
      chk(!(mem_oe_n === 1'b0 && mem_we_n === 1'b0), "R8", "strobe overlap",
          {mem_oe_n, mem_we_n}, 32'h3);
      chk(mem_dq_oe === e_oe, "R6", "dq_oe", 32'(mem_dq_oe), 32'(e_oe));
      if (e_oe) chk(mem_dq_out === m_wdata, "R6", "dq_out", 32'(mem_dq_out), 32'(m_wdata));
      chk(busy === e_busy, "R7", "busy", 32'(busy), 32'(e_busy));
      chk(done === e_done, "R7", "done", 32'(done), 32'(e_done));
      chk(mem_addr === m_addr, "R2,R9", "addr", 32'(mem_addr), 32'(m_addr));
      chk(rd_data === m_rdata, "R4,R10", "rd_data", 32'(rd_data), 32'(m_rdata));
    end
    // valid word only in the final read-pulse clock
    if (mt != 0 && !m_wr && mt == RS + RP) mem_dq_in = dev_word(m_addr);
    else                                    mem_dq_in = ~dev_word(m_addr);
  end

  task automatic issue(input bit wr, input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    while (busy || mt != 0 && mt != m_last) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values while reset is held
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        {mem_cs_n, mem_oe_n, mem_we_n}, 32'h7);
    chk(!mem_dq_oe && !busy && !done, "R1", "flags in reset",
        {mem_dq_oe, busy, done}, 32'h0);
    chk(rd_data == 0 && mem_addr == 0, "R1", "data in reset", 32'(rd_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && !busy && !mem_dq_oe, "R1", "after release",
        {mem_cs_n, busy, mem_dq_oe}, 32'h4);
    // single read, single write, extremes of address and data
    issue(0, 23'h000123, 16'h0);
    issue(1, 23'h7FFFFF, 16'hFFFF);
    issue(1, 23'h000000, 16'h0000);
    issue(0, 23'h7FFFFF, 16'h0);
    issue(0, 23'h000000, 16'h0);
    // R10: a write after a read leaves rd_data alone
    issue(1, 23'h2AAAAA, 16'hA55A);
    // R2: requests with other addresses while busy are ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 23'h155555;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      req_addr = 23'h0F0F00 + 23'(i); req_write = 1'b1; req_wdata = 16'(i * 7);
      @(negedge clk);
    end
    req_valid = 1'b0;
    // back-to-back stream with request held high
    for (int i = 0; i < 40; i++) begin
      req_valid = 1'b1;
      req_write = (i % 3) == 1;
      req_addr  = 23'(i * 40503 + 17);
      req_wdata = 16'(i * 2654 + 3);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    // reset in the middle of a write, then a clean read
    issue(1, 23'h033333, 16'h1234);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    issue(0, 23'h044444, 16'h0);
    repeat (12) @(negedge clk);
    finish_run();
  end

endmodule